// File: doc/BRIEF.md
# Multi-driver bus resolution unit

This block decides the value of a shared signal that several independent sources may drive at once. Each source presents an enable and a data word. A static policy input picks the resolution rule. The rule says what happens when two sources collide, and what value the signal takes when no source drives it. The block returns the resolved word and two error flags. It is meant for models and checkers of shared nets inside larger designs, where tristate pads are not available or not wanted.

Three policies are provided. The exclusive policy allows at most one active source and pulls the signal high when idle. The wired-agreement policy allows any number of active sources as long as they all present the same value, and also pulls high when idle. The hold policy allows at most one active source, like the exclusive policy. When no source drives, the hold policy keeps the last value it resolved in a register clocked on the rising edge. Resolution is combinational for all three policies. Only the held value is stored.

The word width is a parameter, so each bit lane is resolved separately while all lanes share the per-source enables. When a conflict is flagged, the output is still defined. It takes the data of the lowest-numbered active source.

Top module: `bus_resolver`

## Requirements
- R1: The policy input encoding is 2'b00 exclusive, 2'b01 wired-agreement, 2'b10 hold. With policy 2'b00 and exactly one enable set, `bus_val` equals that source's data word in the same cycle and both error flags are 0.
- R2: With policy 2'b00, 2'b01 or 2'b11 and no enable set, `bus_val` is all ones and both error flags are 0.
- R3: With policy 2'b01 and any number of enabled sources that all present the same word, `bus_val` equals that word and `disagree_err` is 0.
- R4: With policy 2'b01, `disagree_err` is 1 in the same cycle if, in any bit lane, two enabled sources present different values. In that case `bus_val` equals the data of the lowest-numbered enabled source, and `multi_err` is 0.
- R5: With policy 2'b00, 2'b10 or 2'b11, `multi_err` is 1 in the same cycle if two or more enables are set. In that case `bus_val` equals the data of the lowest-numbered enabled source. `multi_err` is never 1 under policy 2'b01.
- R6: With policy 2'b10 and at least one enable set, `bus_val` follows the resolved data in the same cycle, and that value is loaded into the held register at the next rising edge. With no enable set, `bus_val` shows the held register.
- R7: A synchronous active-high reset sets the held register to all ones, so policy 2'b10 with no enable set shows all ones right after reset.
- R8: Policy code 2'b11 behaves as the exclusive policy, and it never loads the held register.
- R9: Bit b of source i sits at `drv_data[i*WIDTH+b]`. Each lane of `bus_val` is resolved from its own bits, and all lanes share the source enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the held register updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Resolution policy code |
| drv_en | input | N_DRV | One enable per source |
| drv_data | input | N_DRV*WIDTH | Source data words, source i in bits i*WIDTH +: WIDTH |
| bus_val | output | WIDTH | Resolved word |
| multi_err | output | 1 | More than one source under a single-source policy |
| disagree_err | output | 1 | Enabled sources differ under the wired-agreement policy |

## Verification
The bench builds the block with three sources and a two-bit word. With that setup it can walk every policy code, every enable pattern and every data combination: 4 x 8 x 64 patterns, each held for one clock. This reaches every collision shape, from one source up to all three. It also covers lane-specific disagreement, where one lane agrees and the other does not, and lowest-index selection from each possible winner. The hold policy is followed by a reference model of the held word. That model is loaded only when a hold-policy cycle has an active source, so the sweep also shows that the other policies leave the held word alone. A final reset in the middle of the run checks the return to all ones.

// File: rtl/bus_res_pkg.sv
package bus_res_pkg;

    typedef enum logic [1:0] {
        POL_EXCL     = 2'b00,
        POL_WIRED    = 2'b01,
        POL_HOLD     = 2'b10,
        POL_EXCL_ALT = 2'b11
    } policy_e;

    typedef struct packed {
        logic any_on;
        logic many_on;
    } census_flags_t;

    // Policies under which only one source may be active at a time.
    function automatic logic single_source(policy_e p);
        return (p != POL_WIRED);
    endfunction

    function automatic logic holds_value(policy_e p);
        return (p == POL_HOLD);
    endfunction

endpackage

// File: rtl/brs_census.sv
module brs_census
    import bus_res_pkg::*;
#(
    parameter int N_DRV = 4,
    localparam int IDX_W = (N_DRV > 1) ? $clog2(N_DRV) : 1,
    localparam int CNT_W = $clog2(N_DRV + 1)
) (
    input  logic [N_DRV-1:0] en,
    output census_flags_t    flags,
    output logic [IDX_W-1:0] first_idx
);

    logic [CNT_W-1:0] active_cnt;

    always_comb begin
        active_cnt = '0;
        for (int i = 0; i < N_DRV; i++) begin
            active_cnt = active_cnt + CNT_W'(en[i]);
        end
    end

    // Scan from the top so the lowest set index wins.
    always_comb begin
        first_idx = '0;
        for (int i = N_DRV - 1; i >= 0; i--) begin
            if (en[i]) begin
                first_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        flags.any_on  = (active_cnt != '0);
        flags.many_on = (active_cnt > CNT_W'(1));
    end

endmodule

// File: rtl/brs_lane.sv
module brs_lane
    import bus_res_pkg::*;
#(
    parameter int N_DRV = 4,
    localparam int IDX_W = (N_DRV > 1) ? $clog2(N_DRV) : 1
) (
    input  policy_e          mode,
    input  logic [N_DRV-1:0] en,
    input  logic [N_DRV-1:0] bits,
    input  logic [IDX_W-1:0] first_idx,
    input  logic             any_on,
    input  logic             held_bit,
    output logic             val,
    output logic             clash
);

    logic saw_one;
    logic saw_zero;

    always_comb begin
        saw_one  = |(en & bits);
        saw_zero = |(en & ~bits);
        clash    = saw_one & saw_zero;
    end

    always_comb begin
        if (any_on) begin
            val = bits[first_idx];
        end else if (holds_value(mode)) begin
            val = held_bit;
        end else begin
            val = 1'b1;
        end
    end

endmodule

// File: rtl/brs_hold.sv
module brs_hold #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '1;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/bus_resolver.sv
module bus_resolver
    import bus_res_pkg::*;
#(
    parameter int N_DRV = 4,
    parameter int WIDTH = 1,
    localparam int IDX_W = (N_DRV > 1) ? $clog2(N_DRV) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [1:0]             mode,
    input  logic [N_DRV-1:0]       drv_en,
    input  logic [N_DRV*WIDTH-1:0] drv_data,
    output logic [WIDTH-1:0]       bus_val,
    output logic                   multi_err,
    output logic                   disagree_err
);

    policy_e          policy;
    census_flags_t    flags;
    logic [IDX_W-1:0] first_idx;
    logic [WIDTH-1:0] held;
    logic [WIDTH-1:0] lane_clash;
    logic [N_DRV-1:0] lane_bits [WIDTH];

    assign policy = policy_e'(mode);

    brs_census #(.N_DRV(N_DRV)) u_census (
        .en        (drv_en),
        .flags     (flags),
        .first_idx (first_idx)
    );

    for (genvar b = 0; b < WIDTH; b++) begin : g_lane
        for (genvar i = 0; i < N_DRV; i++) begin : g_gather
            assign lane_bits[b][i] = drv_data[i*WIDTH + b];
        end

        brs_lane #(.N_DRV(N_DRV)) u_lane (
            .mode      (policy),
            .en        (drv_en),
            .bits      (lane_bits[b]),
            .first_idx (first_idx),
            .any_on    (flags.any_on),
            .held_bit  (held[b]),
            .val       (bus_val[b]),
            .clash     (lane_clash[b])
        );
    end

    brs_hold #(.WIDTH(WIDTH)) u_hold (
        .clk  (clk),
        .rst  (rst),
        .load (holds_value(policy) & flags.any_on),
        .d    (bus_val),
        .q    (held)
    );

    assign multi_err    = single_source(policy) & flags.many_on;
    assign disagree_err = (policy == POL_WIRED) & (|lane_clash);

endmodule

// File: rtl/bus_resolver_chk.sv
module bus_resolver_chk #(
    parameter int N_DRV = 4,
    parameter int WIDTH = 1
) (
    input logic                   clk,
    input logic                   rst,
    input logic [1:0]             mode,
    input logic [N_DRV-1:0]       drv_en,
    input logic [N_DRV*WIDTH-1:0] drv_data,
    input logic [WIDTH-1:0]       bus_val,
    input logic                   multi_err,
    input logic                   disagree_err
);

    // R2
    idle_pullup_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'b10 && drv_en == '0) |-> (bus_val == '1 && !multi_err && !disagree_err));

    // R5
    multi_flag_chk: assert property (@(posedge clk) disable iff (rst)
        multi_err |-> (mode != 2'b01 && $countones(drv_en) > 1));

    // R5
    multi_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'b01 && $countones(drv_en) > 1) |-> multi_err);

    // R4
    disagree_scope_chk: assert property (@(posedge clk) disable iff (rst)
        disagree_err |-> (mode == 2'b01 && $countones(drv_en) > 1));

    // R6
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10 && drv_en == '0 && $past(mode) == 2'b10 && !$past(rst))
        |-> (bus_val == $past(bus_val)));

    // R1
    single_clean_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(drv_en) == 1) |-> (!multi_err && !disagree_err));

endmodule

bind bus_resolver bus_resolver_chk #(.N_DRV(N_DRV), .WIDTH(WIDTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .mode         (mode),
    .drv_en       (drv_en),
    .drv_data     (drv_data),
    .bus_val      (bus_val),
    .multi_err    (multi_err),
    .disagree_err (disagree_err)
);

// File: tb/bus_resolver_bench.sv
module bus_resolver_bench;

    localparam int ND = 3;
    localparam int W  = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    mode = 2'b10;
    logic [ND-1:0] drv_en = '0;
    logic [ND*W-1:0] drv_data = '0;
    logic [W-1:0]  bus_val;
    logic          multi_err;
    logic          disagree_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [W-1:0] ref_held;

    always #2 clk = ~clk;

    bus_resolver #(.N_DRV(ND), .WIDTH(W)) u_bus_resolver (
        .clk          (clk),
        .rst          (rst),
        .mode         (mode),
        .drv_en       (drv_en),
        .drv_data     (drv_data),
        .bus_val      (bus_val),
        .multi_err    (multi_err),
        .disagree_err (disagree_err)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int count_on(input int en);
        int c = 0;
        for (int i = 0; i < ND; i++) c += (en >> i) & 1;
        return c;
    endfunction

    function automatic int word_of(input int dat, input int i);
        return (dat >> (i * W)) & ((1 << W) - 1);
    endfunction

    function automatic bit lanes_clash(input int en, input int dat);
        for (int b = 0; b < W; b++) begin
            bit s1 = 0;
            bit s0 = 0;
            for (int i = 0; i < ND; i++) begin
                if ((en >> i) & 1) begin
                    if ((dat >> (i * W + b)) & 1) s1 = 1; else s0 = 1;
                end
            end
            if (s1 && s0) return 1;
        end
        return 0;
    endfunction

    function automatic string pick_tag(input int m, input int en, input int dat);
        if (en == 0) return (m == 2) ? "R6" : "R2";
        if (m == 3) return "R8";
        if (m == 1) return lanes_clash(en, dat) ? "R4" : "R3";
        if (count_on(en) > 1) return "R5";
        if (m == 2) return "R6";
        for (int i = 0; i < ND; i++) begin
            if (((en >> i) & 1) && word_of(dat, i) != 0 && word_of(dat, i) != 3) return "R9";
        end
        return "R1";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        ref_held = '1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R7", "bus_val after reset", int'(bus_val), 3);
        check("R7", "multi_err after reset", int'(multi_err), 0);

        for (int m = 0; m < 4; m++) begin
            for (int en = 0; en < (1 << ND); en++) begin
                for (int dat = 0; dat < (1 << (ND * W)); dat++) begin
                    int first;
                    int exp_val;
                    string tag;
                    @(negedge clk);
                    mode     = 2'(m);
                    drv_en   = ND'(en);
                    drv_data = (ND*W)'(dat);
                    #1;
                    first = -1;
                    for (int i = ND - 1; i >= 0; i--) if ((en >> i) & 1) first = i;
                    if (first < 0) exp_val = (m == 2) ? int'(ref_held) : 3;
                    else exp_val = word_of(dat, first);
                    tag = pick_tag(m, en, dat);
                    check(tag, "bus_val", int'(bus_val), exp_val);
                    check(tag, "multi_err", int'(multi_err), (m != 1 && count_on(en) > 1) ? 1 : 0);
                    check(tag, "disagree_err", int'(disagree_err),
                          (m == 1 && lanes_clash(en, dat)) ? 1 : 0);
                    if (m == 2 && en != 0) ref_held = W'(exp_val);
                end
            end
        end

        // Load a zero word, then reset in the middle of the run: held returns to ones.
        @(negedge clk);
        mode = 2'b10; drv_en = 3'b010; drv_data = 6'b000000;
        @(negedge clk);
        drv_en = '0;
        #1;
        check("R6", "held zero shown", int'(bus_val), 0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R7", "held after mid reset", int'(bus_val), 3);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule